// File: doc/BRIEF.md
# Multi-Address Receive Cell Buffer

This block buffers received ATM cells for a multi-PHY cell bus port. A line-side writer delivers cells byte by byte. The first byte of each cell carries a start marker and one of twelve PHY addresses. Each address has its own queue, and every queue stores whole 53-byte cells. Addresses 0 to 7 are single-line ports with room for two cells each. Addresses 8 to 11 are link-group ports with room for four cells each.

On the bus side, the block picks queues that hold a complete cell in round-robin order. It sends one full cell at a time, with its address and a start-of-cell flag on the first byte. A downstream active-low enable paces the transfer: while the enable is high, the current byte is held.

A cell that finds its queue full is discarded whole, and the overflow is recorded in a sticky per-address status bit. Writing 0 to a status bit clears it. A per-bit enable mask decides which status bits drive the single interrupt output.

Top module: `utp_rx_cell_fifo`

## Requirements
- R1: There are 12 queues. Addresses 0–7 each hold at most 2 cells and addresses 8–11 at most 4 cells. A cell tagged with address 12–15 is consumed and discarded, sets no status bit and is never output.
- R2: Each queue delivers its cells in arrival order with all 53 bytes unchanged.
- R3: A cell whose start byte (wr_valid_i=1, wr_soc_i=1) arrives while its queue is full is dropped entirely, and status bit [address] is set. Fullness is judged on the state before the clock edge, so a slot freed by a final read byte on the same edge is usable only from the next cycle.
- R4: Every output cell is 53 transfers long, and rx_soc_o is 1 only on its first byte.
- R5: A byte is transferred on an edge where rx_valid_o=1 and rx_enb_ni=0. While rx_enb_ni=1, rx_valid_o, rx_addr_o, rx_data_o and rx_soc_o hold.
- R6: Selection is round-robin among queues holding a complete cell. The search starts after the last address served, and after reset it starts at address 0. Cells are never interleaved. A cell becomes eligible the cycle after its last byte is written. Selection takes one edge, so rx_valid_o stays low for exactly one cycle after a cell's last transfer and then rises if any cell is ready. rx_addr_o gives the served address.
- R7: Status bits are sticky. A write with csr_wr_i=1 and csr_sel_i=0 clears each status bit whose csr_wdata_i bit is 0 and leaves bits written 1 unchanged. An overflow on the same edge wins over the clear.
- R8: A write with csr_wr_i=1 and csr_sel_i=1 loads the 12-bit interrupt enable mask. irq_o is the OR over all bits of status AND enable.
- R9: A valid byte with no cell in progress and wr_soc_i=0 is ignored. Inside a cell, wr_soc_i and wr_addr_i are ignored, and the byte is stored as data.
- R10: After reset, rx_valid_o=0, ovf_sts_o=0, irq_o=0 and the enable mask is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write byte valid |
| wr_soc_i | input | 1 | Write byte is first byte of a cell |
| wr_addr_i | input | 4 | PHY address, sampled on the start byte |
| wr_data_i | input | 8 | Write byte |
| rx_enb_ni | input | 1 | Downstream enable, active low |
| rx_valid_o | output | 1 | Output byte valid |
| rx_soc_o | output | 1 | Output byte is first byte of a cell |
| rx_addr_o | output | 4 | Address of the cell being sent |
| rx_data_o | output | 8 | Output byte |
| csr_wr_i | input | 1 | Register write strobe |
| csr_sel_i | input | 1 | 0: status clear, 1: enable mask |
| csr_wdata_i | input | 12 | Register write data |
| ovf_sts_o | output | 12 | Sticky overflow status |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is an overflow, together with its one-cycle boundary, where a queue frees its last slot on the same edge that a new start byte arrives for it. To fill queues, the stimulus first holds the downstream enable high. Then a long phase sends cells at a write rate well above the randomly throttled read rate, so full queues, drops and the freed-slot edge occur often. A behavioural model with per-address byte queues checks every output on every cycle.

// File: rtl/rxcf_pkg.sv
package rxcf_pkg;
  localparam int CELL_BYTES = 53;
  localparam int BIDX_W     = $clog2(CELL_BYTES);
  typedef logic [BIDX_W-1:0] bidx_t;
  typedef logic [7:0]        byte_t;
  localparam bidx_t LAST_IDX = bidx_t'(CELL_BYTES - 1);
  localparam logic CSR_STS = 1'b0;
  localparam logic CSR_IEN = 1'b1;
endpackage

// File: rtl/rxcf_queue.sv
module rxcf_queue import rxcf_pkg::*; #(
  parameter int DEPTH = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_start_i,
  input  logic  wr_en_i,
  input  bidx_t wr_idx_i,
  input  byte_t wr_data_i,
  input  bidx_t rd_idx_i,
  input  logic  rd_done_i,
  output byte_t rd_data_o,
  output logic  full_o,
  output logic  ready_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int MW = $clog2(DEPTH * CELL_BYTES);

  byte_t          mem [DEPTH*CELL_BYTES];
  logic [PW-1:0]  wr_ptr, rd_ptr;
  logic [CW-1:0]  used, done_cnt;
  logic [MW-1:0]  wa, ra;
  logic           wr_last;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign wr_last = wr_en_i && (wr_idx_i == LAST_IDX);
  assign wa      = MW'(int'(wr_ptr) * CELL_BYTES + int'(wr_idx_i));
  assign ra      = MW'(int'(rd_ptr) * CELL_BYTES + int'(rd_idx_i));

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wa] <= wr_data_i;
  end

  assign rd_data_o = mem[ra];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      used     <= '0;
      done_cnt <= '0;
    end else begin
      used     <= used + CW'(wr_start_i) - CW'(rd_done_i);
      done_cnt <= done_cnt + CW'(wr_last) - CW'(rd_done_i);
      if (wr_last)   wr_ptr <= nxt(wr_ptr);
      if (rd_done_i) rd_ptr <= nxt(rd_ptr);
    end
  end

  assign full_o  = (used == CW'(DEPTH));
  assign ready_o = (done_cnt != '0);

  // R1
  occ_le_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used <= CW'(DEPTH));
  // R3
  start_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start_i |-> !full_o);
  // R2
  done_le_used_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_cnt <= used);
  // R6
  rd_when_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_i |-> ready_o);
endmodule

// File: rtl/rxcf_rr_arb.sv
module rxcf_rr_arb #(
  parameter int N  = 12,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          adv_i,
  output logic [IW-1:0] gnt_o,
  output logic          vld_o
);
  logic [IW-1:0] last_q;

  always_comb begin
    gnt_o = '0;
    vld_o = 1'b0;
    for (int i = 1; i <= N; i++) begin
      int j;
      j = (int'(last_q) + i) % N;
      if (!vld_o && req_i[j]) begin
        vld_o = 1'b1;
        gnt_o = IW'(j);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              last_q <= IW'(N - 1);
    else if (adv_i && vld_o)  last_q <= gnt_o;
  end

  // R6
  gnt_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> req_i[gnt_o]);
  // R6
  gnt_any_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> vld_o);
endmodule

// File: rtl/rxcf_ovf_regs.sv
module rxcf_ovf_regs import rxcf_pkg::*; #(
  parameter int N = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         wr_i,
  input  logic         sel_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] sts_o,
  output logic         irq_o
);
  logic [N-1:0] sts_q, ien_q, keep;

  assign keep = (wr_i && sel_i == CSR_STS) ? wdata_i : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      ien_q <= '0;
    end else begin
      sts_q <= (sts_q & keep) | set_i;
      if (wr_i && sel_i == CSR_IEN) ien_q <= wdata_i;
    end
  end

  assign sts_o = sts_q;
  assign irq_o = |(sts_q & ien_q);

  // R7
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ((sts_o & $past(sts_o)) == $past(sts_o)));
  // R3
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((sts_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/utp_rx_cell_fifo.sv
module utp_rx_cell_fifo import rxcf_pkg::*; #(
  parameter int NUM_UNI   = 8,
  parameter int NUM_GRP   = 4,
  parameter int UNI_CELLS = 2,
  parameter int GRP_CELLS = 4,
  localparam int NQ = NUM_UNI + NUM_GRP,
  localparam int AW = $clog2(NQ)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic          wr_soc_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          rx_enb_ni,
  output logic          rx_valid_o,
  output logic          rx_soc_o,
  output logic [AW-1:0] rx_addr_o,
  output logic [7:0]    rx_data_o,
  input  logic          csr_wr_i,
  input  logic          csr_sel_i,
  input  logic [NQ-1:0] csr_wdata_i,
  output logic [NQ-1:0] ovf_sts_o,
  output logic          irq_o
);
  // write side
  logic          w_busy, w_keep;
  logic [AW-1:0] w_addr;
  bidx_t         w_cnt, q_widx;
  logic          soc_take;
  logic [NQ-1:0] hit, q_full, q_ready, q_start, q_wen, q_done, ovf_set;
  byte_t         q_rdata [NQ];

  assign soc_take = wr_valid_i && wr_soc_i && !w_busy;
  assign q_widx   = w_busy ? w_cnt : '0;

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      hit[q]   = soc_take && (wr_addr_i == AW'(q));
      q_wen[q] = (hit[q] && !q_full[q]) ||
                 (w_busy && w_keep && wr_valid_i && (w_addr == AW'(q)));
    end
  end

  assign q_start = hit & ~q_full;
  assign ovf_set = hit & q_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_busy <= 1'b0;
      w_keep <= 1'b0;
      w_addr <= '0;
      w_cnt  <= '0;
    end else if (soc_take) begin
      w_busy <= 1'b1;
      w_keep <= |q_start;
      w_addr <= wr_addr_i;
      w_cnt  <= bidx_t'(1);
    end else if (w_busy && wr_valid_i) begin
      w_cnt <= w_cnt + 1'b1;
      if (w_cnt == LAST_IDX) w_busy <= 1'b0;
    end
  end

  // queues, sized by address class
  for (genvar g = 0; g < NQ; g++) begin : g_q
    localparam int DEP = (g < NUM_UNI) ? UNI_CELLS : GRP_CELLS;
    rxcf_queue #(.DEPTH(DEP)) u_q (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_start_i (q_start[g]),
      .wr_en_i    (q_wen[g]),
      .wr_idx_i   (q_widx),
      .wr_data_i  (wr_data_i),
      .rd_idx_i   (rd_cnt),
      .rd_done_i  (q_done[g]),
      .rd_data_o  (q_rdata[g]),
      .full_o     (q_full[g]),
      .ready_o    (q_ready[g])
    );
  end

  // read side
  logic          rd_act, xfer, rd_last, gnt_vld;
  logic [AW-1:0] rd_q, gnt_idx;
  bidx_t         rd_cnt;

  assign xfer    = rd_act && !rx_enb_ni;
  assign rd_last = xfer && (rd_cnt == LAST_IDX);

  rxcf_rr_arb #(.N(NQ)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (q_ready),
    .adv_i  (!rd_act),
    .gnt_o  (gnt_idx),
    .vld_o  (gnt_vld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_act <= 1'b0;
      rd_q   <= '0;
      rd_cnt <= '0;
    end else if (!rd_act) begin
      if (gnt_vld) begin
        rd_act <= 1'b1;
        rd_q   <= gnt_idx;
        rd_cnt <= '0;
      end
    end else if (xfer) begin
      rd_cnt <= rd_cnt + 1'b1;
      if (rd_cnt == LAST_IDX) rd_act <= 1'b0;
    end
  end

  always_comb begin
    for (int q = 0; q < NQ; q++) q_done[q] = rd_last && (rd_q == AW'(q));
  end

  assign rx_valid_o = rd_act;
  assign rx_soc_o   = rd_act && (rd_cnt == '0);
  assign rx_addr_o  = rd_q;
  assign rx_data_o  = q_rdata[rd_q];

  rxcf_ovf_regs #(.N(NQ)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (ovf_set),
    .wr_i    (csr_wr_i),
    .sel_i   (csr_sel_i),
    .wdata_i (csr_wdata_i),
    .sts_o   (ovf_sts_o),
    .irq_o   (irq_o)
  );

  // R5
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && rx_enb_ni) |=> (rx_valid_o && $stable(rx_data_o) &&
                                   $stable(rx_addr_o) && $stable(rx_soc_o)));
  // R4
  soc_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_valid_o) |-> rx_soc_o);
  // R6
  no_interleave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && $past(rx_valid_o)) |-> $stable(rx_addr_o));
  // R6
  gap_after_cell_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_last |=> !rx_valid_o);
endmodule

// File: tb/utp_rx_cell_fifo_bench.sv
`timescale 1ns/1ps
module utp_rx_cell_fifo_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        wv = 0, ws = 0, enb_n = 1, cw = 0, cs = 0;
  logic [3:0]  wa = 0;
  logic [7:0]  wd = 0;
  logic [11:0] cd = 0;
  logic        rx_valid, rx_soc, irq;
  logic [3:0]  rx_addr;
  logic [7:0]  rx_data;
  logic [11:0] sts;

  utp_rx_cell_fifo u_utp_rx_cell_fifo (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wv), .wr_soc_i(ws),
    .wr_addr_i(wa), .wr_data_i(wd), .rx_enb_ni(enb_n),
    .rx_valid_o(rx_valid), .rx_soc_o(rx_soc), .rx_addr_o(rx_addr),
    .rx_data_o(rx_data), .csr_wr_i(cw), .csr_sel_i(cs),
    .csr_wdata_i(cd), .ovf_sts_o(sts), .irq_o(irq)
  );

  int n_chk = 0, n_err = 0, cyc = 0, enb_mode = 1;
  int got [16];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0]  mq [12][$];
  int          used [12], rdy [12];
  bit          m_act, w_busy, w_keep;
  int          m_cur, m_idx, m_last, w_cnt, w_a;
  logic [11:0] m_sts, m_ien, setm;
  bit          fo [12];
  int          ro [12];
  bit          found;

  function automatic int dep(input int a);
    return (a < 8) ? 2 : 4;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < 12; a++) begin
        mq[a].delete(); used[a] = 0; rdy[a] = 0;
      end
      m_act = 0; w_busy = 0; w_keep = 0; m_cur = 0; m_idx = 0; m_last = 11;
      w_cnt = 0; w_a = 0; m_sts = 0; m_ien = 0;
    end else begin
      for (int a = 0; a < 12; a++) begin
        fo[a] = (used[a] == dep(a)); ro[a] = rdy[a];
      end
      if (m_act) begin
        if (!enb_n) begin
          void'(mq[m_cur].pop_front());
          m_idx++;
          if (m_idx == 53) begin
            m_act = 0; used[m_cur]--; rdy[m_cur]--;
          end
        end
      end else begin
        found = 0;
        for (int i = 1; i <= 12; i++) begin
          int j;
          j = (m_last + i) % 12;
          if (!found && ro[j] > 0) begin
            found = 1; m_act = 1; m_cur = j; m_idx = 0; m_last = j;
          end
        end
      end
      setm = 0;
      if (wv) begin
        if (!w_busy) begin
          if (ws) begin
            w_busy = 1; w_cnt = 1; w_a = int'(wa); w_keep = 0;
            if (w_a < 12) begin
              if (!fo[w_a]) begin
                w_keep = 1; used[w_a]++; mq[w_a].push_back(wd);
              end else setm[w_a] = 1'b1;
            end
          end
        end else begin
          if (w_keep) mq[w_a].push_back(wd);
          w_cnt++;
          if (w_cnt == 53) begin
            w_busy = 0;
            if (w_keep) rdy[w_a]++;
          end
        end
      end
      if (cw && !cs) m_sts = m_sts & cd;
      if (cw && cs)  m_ien = cd;
      m_sts = m_sts | setm;
    end
  end

  // compare on every cycle, away from the active edge
  bit pend;
  int pend_a;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(rx_valid == m_act, "R6 valid", rx_valid, m_act);
      if (m_act) begin
        chk(rx_soc == (m_idx == 0), "R4 soc", rx_soc, m_idx == 0);
        chk(int'(rx_addr) == m_cur, "R6 addr", rx_addr, m_cur);
        chk(rx_data == mq[m_cur][0], "R2 R9 data", rx_data, mq[m_cur][0]);
      end
      chk(sts == m_sts, "R3 R7 status", sts, m_sts);
      chk(irq == |(m_sts & m_ien), "R8 irq", irq, |(m_sts & m_ien));
      pend = rx_valid && rx_soc; pend_a = int'(rx_addr);
    end else pend = 0;
  end
  always @(posedge clk) if (rst_n && pend && !enb_n) got[pend_a]++;

  always @(negedge clk) begin
    case (enb_mode)
      0: enb_n = 1'b0;
      1: enb_n = 1'b1;
      default: enb_n = 1'($urandom % 2);
    endcase
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic send_cell(input int a, input int base, input bit gaps, input bit socmid);
    for (int i = 0; i < 53; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        wv = 0; @(negedge clk);
      end
      wv = 1;
      ws = (i == 0) || (socmid && i == 20);
      wa = (i == 0) ? 4'(a) : 4'($urandom);
      wd = 8'(base + i);
      @(negedge clk);
    end
    wv = 0; ws = 0;
  endtask

  task automatic csr(input bit sel, input logic [11:0] d);
    cw = 1; cs = sel; cd = d;
    @(negedge clk);
    cw = 0;
  endtask

  task automatic stray(input int n);
    for (int i = 0; i < n; i++) begin
      wv = 1; ws = 0; wa = 4'($urandom); wd = 8'($urandom);
      @(negedge clk);
    end
    wv = 0;
  endtask

  initial begin
    for (int a = 0; a < 16; a++) got[a] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rx_valid == 0, "R10 reset valid", rx_valid, 0);
    chk(sts == 0, "R10 reset status", sts, 0);
    chk(irq == 0, "R10 reset irq", irq, 0);

    // output held off: fill queues and force overflows
    enb_mode = 1;
    stray(5);
    for (int k = 0; k < 3; k++) send_cell(3, 8'h10 + k * 8'h40, 0, 0);
    for (int k = 0; k < 5; k++) send_cell(9, 8'h20 + k * 8'h30, 0, k == 1);
    send_cell(13, 8'h77, 0, 0);
    stray(3);
    repeat (4) @(negedge clk);
    chk(sts == 12'h208, "R3 overflow bits", sts, 12'h208);
    chk(irq == 0, "R8 irq masked", irq, 0);
    chk(rx_valid == 1 && rx_addr == 3, "R6 first pick", rx_addr, 3);
    chk(rx_data == 8'h10 && rx_soc == 1, "R5 stalled byte", rx_data, 8'h10);
    repeat (3) @(negedge clk);
    chk(rx_data == 8'h10 && rx_valid == 1, "R5 still held", rx_data, 8'h10);
    csr(1, 12'h200);
    chk(irq == 1, "R8 irq enabled", irq, 1);
    csr(0, ~12'h008);
    chk(sts == 12'h200, "R7 clear bit 3", sts, 12'h200);
    csr(0, 12'hfff);
    chk(sts == 12'h200, "R7 write ones keeps", sts, 12'h200);
    csr(1, 12'h000);
    chk(irq == 0, "R8 irq disabled", irq, 0);

    // drain
    enb_mode = 0;
    repeat (500) @(negedge clk);
    chk(got[3] == 2, "R1 uni depth 2", got[3], 2);
    chk(got[9] == 4, "R1 group depth 4", got[9], 4);
    chk(got[13] == 0, "R1 bad address ignored", got[13], 0);
    chk(rx_valid == 0, "R6 idle after drain", rx_valid, 0);

    // random traffic with throttled output
    enb_mode = 2;
    for (int k = 0; k < 300; k++) begin
      int a;
      a = ($urandom % 10 == 0) ? 12 + int'($urandom % 4) : int'($urandom % 12);
      send_cell(a, int'($urandom), 1, ($urandom % 8) == 0);
      if ($urandom % 6 == 0) csr(1'($urandom), 12'($urandom));
      if ($urandom % 5 == 0) stray(1 + int'($urandom % 3));
    end
    enb_mode = 0;
    repeat (1500) @(negedge clk);
    chk(rx_valid == 0, "R2 all drained", rx_valid, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule